// File: doc/BRIEF.md
# Five-Level Single-Carrier PWM Gate Generator

This block produces the five gate-drive bits for a single-source bridge with five output levels. The bridge has four main switches and one auxiliary switch that gives access to the half-supply level. A unipolar triangular carrier runs from 0 to a peak `A`. Two references are compared against that one carrier. The upper reference is the scaled sine magnitude, and the lower reference is the same magnitude shifted down by `A`. Together the two comparisons pick full, half or zero amplitude. The sign of the sine selects the polarity.

A phase accumulator advances by `phase_step` once per carrier period, at the carrier peak. The sine magnitude for the new phase is computed, scaled by `mod_idx` and held until the next peak. Every clock the held sample is sliced against the carrier. The level code and the matching switch pattern are registered together. While `en` is low, or during reset, the block forces an idle pattern.

Top module: `fivelvl_pwm`

## Requirements
- R1: Gate bits are `gate_o[0]`=S1 (auxiliary), `gate_o[1]`=S2, `gate_o[2]`=S3, `gate_o[3]`=S4, `gate_o[4]`=S5. The patterns are:
  - +full = S2+S5 (`5'b10010`)
  - +half = S1+S5 (`5'b10001`)
  - zero = S3+S5 (`5'b10100`)
  - −half = S1+S4 (`5'b01001`)
  - −full = S3+S4 (`5'b01100`)
- R2: `level_o` is a 3-bit two's-complement code: +2 for +full, +1 for +half, 0 for zero, −1 for −half and −2 for −full. It is registered on the same edge as the `gate_o` bits it matches.
- R3: The carrier is 0 after idle and rises by one per enabled clock up to `A`. It then falls by one back to 0 and repeats, so one period is 2·`A` clocks.
- R4: The phase and the held reference sample change only on an enabled edge where the carrier equals `A`. On that edge the phase becomes phase+`phase_step`, and the sample is computed from that new phase.
  - The sign is phase bit `PW`−1.
  - `p` is the next `LW` bits of the phase.
  - The raw magnitude is floor(p·(2^LW − p)·8·A / 2^(2·LW)).
- R5: The held magnitude is floor(raw·`mod_idx` / 2^(MW−1)), limited to 2·A.
- R6: On each enabled edge the level is taken from the carrier and held sample present before that edge:
  - full if the magnitude exceeds carrier+A;
  - otherwise half if the magnitude exceeds the carrier;
  - otherwise zero.
  - Full and half take the sign; zero has no sign.
- R7: With reset high, or on any edge where `en` is low, the outputs become the idle state: `level_o`=0 and `gate_o`=`5'b10100` (default variant). The carrier, phase and sample also return to 0.
- R8: At most two gate bits are high at once. S4 and S5 are never both high, and S2 and S3 are never both high.
- R9: With `mod_idx`=0 the level stays 0 and `gate_o` stays `5'b10100`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces idle |
| mod_idx | input | MW | Modulation index, unity at 2^(MW−1) |
| phase_step | input | PW | Phase added once per carrier period |
| gate_o | output | 5 | Gate bits S1..S5 (bit 0 = S1) |
| level_o | output | 3 | Signed output level code |

## Verification
Most internal faults show up at the ports within one carrier period. A carrier that miscounts or turns at the wrong value shifts the instant the level changes inside a period. A wrong held sample or saturation changes the duty of the full and half levels from the very next peak. A phase that advances at the wrong time shows up as a polarity flip in the wrong period. An encoder fault shows up on the same edge as a gate pattern that does not match the level code, or as a shorted leg.

// File: rtl/fivelvl_pkg.sv
package fivelvl_pkg;
   typedef logic signed [2:0] lvl_t;

   localparam lvl_t LV_POS_FULL = 3'sd2;
   localparam lvl_t LV_POS_HALF = 3'sd1;
   localparam lvl_t LV_ZERO     = 3'sd0;
   localparam lvl_t LV_NEG_HALF = -3'sd1;
   localparam lvl_t LV_NEG_FULL = -3'sd2;

   localparam logic [4:0] GP_POS_FULL = 5'b10010;
   localparam logic [4:0] GP_POS_HALF = 5'b10001;
   localparam logic [4:0] GP_ZERO     = 5'b10100;
   localparam logic [4:0] GP_NEG_HALF = 5'b01001;
   localparam logic [4:0] GP_NEG_FULL = 5'b01100;

   function automatic logic [4:0] gates_for(input lvl_t l);
      case (l)
         LV_POS_FULL: gates_for = GP_POS_FULL;
         LV_POS_HALF: gates_for = GP_POS_HALF;
         LV_NEG_HALF: gates_for = GP_NEG_HALF;
         LV_NEG_FULL: gates_for = GP_NEG_FULL;
         default:     gates_for = GP_ZERO;
      endcase
   endfunction
endpackage

// File: rtl/fl_carrier.sv
module fl_carrier #(
   parameter int A  = 15,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   output logic [CW-1:0] car_o,
   output logic          peak_o
);
   localparam logic [CW-1:0] TOP = CW'(A);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic rising;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         car_o  <= '0;
         rising <= 1'b1;
      end else if (rising) begin
         car_o <= car_o + ONE;
         if (car_o + ONE == TOP) rising <= 1'b0;
      end else begin
         car_o <= car_o - ONE;
         if (car_o == ONE) rising <= 1'b1;
      end
   end

   assign peak_o = (car_o == TOP);

   a_r3_carrier_bounded: assert property (@(posedge clk) disable iff (rst)
      car_o <= TOP);
   a_r3_carrier_unit_step: assert property (@(posedge clk) disable iff (rst)
      (en && $past(en) && !$past(rst)) |->
         ((car_o == $past(car_o) + ONE) || (car_o + ONE == $past(car_o))));
endmodule

// File: rtl/fl_refgen.sv
module fl_refgen #(
   parameter int A  = 15,
   parameter int PW = 16,
   parameter int LW = 6,
   parameter int MW = 8,
   parameter int RW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic          peak,
   input  logic [PW-1:0] step,
   input  logic [MW-1:0] mi,
   output logic [RW-1:0] ref_o,
   output logic          neg_o
);
   localparam int PRW = 2 * LW + 2;
   localparam int MGW = PRW + RW + 4;
   localparam int SW  = RW + MW + 1;
   localparam logic [RW-1:0] CEIL = RW'(2 * A);

   logic [PW-1:0]  phase, phase_n;
   logic [LW-1:0]  p;
   logic [LW:0]    p_c;
   logic [PRW-1:0] prod;
   logic [MGW-1:0] raw_w;
   logic [RW-1:0]  raw;
   logic [SW-1:0]  scaled;
   logic [RW-1:0]  sample;

   always_comb begin
      phase_n = phase + step;
      p       = phase_n[PW-2 -: LW];
      p_c     = (LW+1)'(2 ** LW) - (LW+1)'(p);
      prod    = PRW'(p) * PRW'(p_c);
      raw_w   = (MGW'(prod) * MGW'(8 * A)) >> (2 * LW);
      raw     = RW'(raw_w);
      scaled  = (SW'(raw) * SW'(mi)) >> (MW - 1);
      sample  = (scaled > SW'(CEIL)) ? CEIL : RW'(scaled);
   end

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         phase <= '0;
         ref_o <= '0;
         neg_o <= 1'b0;
      end else if (peak) begin
         phase <= phase_n;
         ref_o <= sample;
         neg_o <= phase_n[PW-1];
      end
   end

   a_r4_hold_between_peaks: assert property (@(posedge clk) disable iff (rst)
      (en && !peak) |=> ($stable(ref_o) || !en));
   a_r5_saturated: assert property (@(posedge clk) disable iff (rst)
      ref_o <= CEIL);
endmodule

// File: rtl/fl_slicer.sv
module fl_slicer
   import fivelvl_pkg::*;
#(
   parameter int A        = 15,
   parameter int CW       = 4,
   parameter int RW       = 5,
   parameter bit IDLE_OFF = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic [CW-1:0] car,
   input  logic [RW-1:0] ref_i,
   input  logic          neg,
   output logic [4:0]    gate_o,
   output lvl_t          lvl_o
);
   logic [4:0] idle_pat;
   logic       over_lo, over_hi;
   lvl_t       lvl_n;

   generate
      if (IDLE_OFF) begin : g_idle_off
         assign idle_pat = 5'b00000;
      end else begin : g_idle_zero
         assign idle_pat = GP_ZERO;
      end
   endgenerate

   always_comb begin
      over_hi = ref_i > (RW'(car) + RW'(A));
      over_lo = ref_i > RW'(car);
      if (over_hi)      lvl_n = neg ? LV_NEG_FULL : LV_POS_FULL;
      else if (over_lo) lvl_n = neg ? LV_NEG_HALF : LV_POS_HALF;
      else              lvl_n = LV_ZERO;
   end

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         lvl_o  <= LV_ZERO;
         gate_o <= idle_pat;
      end else begin
         lvl_o  <= lvl_n;
         gate_o <= gates_for(lvl_n);
      end
   end

   a_r8_two_gates_max: assert property (@(posedge clk) disable iff (rst)
      $countones(gate_o) <= 2);
   a_r8_no_leg_short: assert property (@(posedge clk) disable iff (rst)
      !(gate_o[3] && gate_o[4]) && !(gate_o[1] && gate_o[2]));
   a_r7_idle_after_disable: assert property (@(posedge clk) disable iff (rst)
      !en |=> (lvl_o == LV_ZERO && gate_o == idle_pat));
   a_r2_level_in_range: assert property (@(posedge clk) disable iff (rst)
      lvl_o != 3'sb100 && lvl_o != 3'sb011);
endmodule

// File: rtl/fivelvl_pwm.sv
module fivelvl_pwm #(
   parameter int A        = 15,
   parameter int PW       = 16,
   parameter int LW       = 6,
   parameter int MW       = 8,
   parameter bit IDLE_OFF = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic [MW-1:0] mod_idx,
   input  logic [PW-1:0] phase_step,
   output logic [4:0]    gate_o,
   output logic [2:0]    level_o
);
   localparam int CW = $clog2(A + 1);
   localparam int RW = $clog2(2 * A + 1);

   generate
      if (A < 2) begin : g_bad_a
         $error("carrier peak must be at least 2");
      end
      if (PW <= LW || LW < 2) begin : g_bad_phase
         $error("phase width must exceed table address width");
      end
      if (MW < 2) begin : g_bad_mi
         $error("modulation word too narrow");
      end
   endgenerate

   logic [CW-1:0] car;
   logic          peak;
   logic [RW-1:0] ref_s;
   logic          neg_s;
   fivelvl_pkg::lvl_t lvl;

   fl_carrier #(.A(A), .CW(CW)) u_car (
      .clk(clk), .rst(rst), .en(en), .car_o(car), .peak_o(peak));

   fl_refgen #(.A(A), .PW(PW), .LW(LW), .MW(MW), .RW(RW)) u_ref (
      .clk(clk), .rst(rst), .en(en), .peak(peak), .step(phase_step),
      .mi(mod_idx), .ref_o(ref_s), .neg_o(neg_s));

   fl_slicer #(.A(A), .CW(CW), .RW(RW), .IDLE_OFF(IDLE_OFF)) u_slc (
      .clk(clk), .rst(rst), .en(en), .car(car), .ref_i(ref_s), .neg(neg_s),
      .gate_o(gate_o), .lvl_o(lvl));

   assign level_o = lvl;
endmodule

// File: tb/sim_fivelvl_pwm.sv
`timescale 1ns/1ps
module sim_fivelvl_pwm;
   localparam int A = 15, PW = 16, LW = 6, MW = 8;

   logic clk = 1'b0, rst = 1'b1, en = 1'b0;
   logic [MW-1:0] mi = '0;
   logic [PW-1:0] step = '0;
   logic [4:0] gate;
   logic [2:0] lvl;
   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   fivelvl_pwm #(.A(A), .PW(PW), .LW(LW), .MW(MW)) u0 (
      .clk(clk), .rst(rst), .en(en), .mod_idx(mi), .phase_step(step),
      .gate_o(gate), .level_o(lvl));

   // reference model built from the requirement text
   int m_car, m_ref, m_lvl;
   bit m_up, m_neg;
   logic [PW-1:0] m_phase, np;

   function automatic int sample_of(input logic [PW-1:0] ph, input int k);
      longint pp, raw, sc;
      pp  = longint'(ph[PW-2 -: LW]);
      raw = (pp * ((longint'(1) << LW) - pp) * 8 * A) >> (2 * LW);
      sc  = (raw * k) >> (MW - 1);
      if (sc > 2 * A) sc = 2 * A;
      return int'(sc);
   endfunction

   function automatic logic [4:0] pat(input int l);
      case (l)
         2: pat = 5'b10010;
         1: pat = 5'b10001;
         -1: pat = 5'b01001;
         -2: pat = 5'b01100;
         default: pat = 5'b10100;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst || !en) begin
         m_car <= 0; m_up <= 1'b1; m_phase <= '0; m_ref <= 0; m_neg <= 1'b0; m_lvl <= 0;
      end else begin
         if (m_ref > m_car + A)  m_lvl <= m_neg ? -2 : 2;       // R6
         else if (m_ref > m_car) m_lvl <= m_neg ? -1 : 1;
         else                    m_lvl <= 0;
         if (m_up) begin
            m_car <= m_car + 1; if (m_car + 1 == A) m_up <= 1'b0;  // R3
         end else begin
            m_car <= m_car - 1; if (m_car - 1 == 0) m_up <= 1'b1;
         end
         if (m_car == A) begin                                  // R4 R5
            np = m_phase + step;
            m_phase <= np;
            m_ref <= sample_of(np, int'(mi));
            m_neg <= np[PW-1];
         end
      end
   end

   bit seen[5];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic run_cycles(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk($signed(lvl) == m_lvl, req, $signed(lvl), m_lvl);
         chk(gate == pat($signed(lvl)), "R1", gate, pat($signed(lvl)));
         chk($countones(gate) <= 2 && !(gate[3] && gate[4]) && !(gate[1] && gate[2]),
             "R8", gate, 0);
         seen[$signed(lvl) + 2] = 1'b1;
      end
   endtask

   task automatic t_reset;
      rst = 1'b1; en = 1'b0;
      repeat (3) @(negedge clk);
      chk(gate == 5'b10100, "R7", gate, 5'b10100);
      chk(lvl == 3'b000, "R7", lvl, 0);
      rst = 1'b0; en = 1'b1;
   endtask

   task automatic t_zero_index;
      mi = 8'd0; step = 16'd2048;
      run_cycles(4 * 2 * A, "R9");
      chk(!seen[0] && !seen[1] && !seen[3] && !seen[4], "R9", 1, 0);
   endtask

   task automatic t_unity;
      en = 1'b0; @(negedge clk); en = 1'b1; mi = 8'd128; step = 16'd2048;
      for (int k = 0; k < 5; k++) seen[k] = 1'b0;
      run_cycles(34 * 2 * A, "R6");
      for (int k = 0; k < 5; k++) chk(seen[k], "R2", seen[k], 1);
   endtask

   task automatic t_overmod;
      mi = 8'd255; step = 16'd3000;
      run_cycles(20 * 2 * A, "R5");
   endtask

   task automatic t_slow_phase;
      mi = 8'd100; step = 16'd777;
      run_cycles(12 * 2 * A, "R4");
   endtask

   task automatic t_enable_drop;
      mi = 8'd128; step = 16'd4096;
      run_cycles(5 * 2 * A + 7, "R3");
      en = 1'b0;
      @(negedge clk);
      chk(gate == 5'b10100, "R7", gate, 5'b10100);
      chk(lvl == 3'b000, "R7", lvl, 0);
      en = 1'b1;
      run_cycles(6 * 2 * A, "R3");
   endtask

   initial begin
      for (int k = 0; k < 5; k++) seen[k] = 1'b0;
      @(negedge clk);
      t_reset();
      for (int k = 0; k < 5; k++) seen[k] = 1'b0;
      t_zero_index();
      t_unity();
      t_overmod();
      t_slow_phase();
      t_enable_drop();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule